// File: doc/BRIEF.md
# Selectable-Timebase Counter with Idle Freeze

This block is a free-running up-counter whose advance pulse is drawn from one of six timebase sources, picked by a three-bit select field in an eight-bit mode register. The sources are two fixed prescalers of the system clock (divide by 12 and by 4), a one-cycle pulse from a neighbouring timer, falling edges of an asynchronous external pin, the system clock itself, and an independent oscillator divided by 8 and brought into the system clock domain. The two remaining select codes are reserved and hold the counter still.

The mode register also carries a bit that freezes counting whenever the processor reports idle, and a bit that lets the sticky wrap flag raise an interrupt request. Software reaches the mode register at bus address 0 and the wrap flag at bus address 1 over a single-cycle write, combinational read register port. The count value, the flag and the request are also driven straight out as ports.

Top module: `cnt_tbsel_top`

## Requirements
- R1: After reset the mode register reads 0x00, the count is 0, and the wrap flag and interrupt request are both low.
- R2: A write to address 0 stores bit 7 (idle freeze), bits 3..1 (timebase select) and bit 0 (interrupt enable). A read of address 0 returns those bits with bits 6..4 always zero.
- R3: Select 000 advances the count once every 12 clocks. When a write changes the select to 000, the first advance lands on the 12th rising edge after the write edge.
- R4: Select 001 advances the count once every 4 clocks. The first advance after a write that changes the select to 001 lands on the 4th rising edge after the write edge.
- R5: Select 010 advances the count by one on each rising edge at which `t0_ovf_i` is high.
- R6: Select 100 advances the count by one on every rising edge.
- R7: Select 011 counts each high-to-low transition of `ext_cnt_i` exactly once when the pin holds each level for at least 2 clocks. Each count lands within 4 clocks of the transition.
- R8: Select 101 advances the count once for every 8 rising edges of `osc_clk_i`.
- R9: Select 110 and select 111 never advance the count.
- R10: With mode bit 7 set and `idle_i` high, the count and the prescalers hold. With bit 7 clear, `idle_i` has no effect.
- R11: An advance from all-ones to zero sets the wrap flag, which reads as bit 0 of address 1. The flag stays set until a write to address 1 with data bit 0 equal to 0. A write with data bit 0 equal to 1 leaves it unchanged.
- R12: `irq_o` is high exactly when the wrap flag is set and mode bit 0 is 1.
- R13: The count changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Processor idle indication |
| t0_ovf_i | input | 1 | One-cycle overflow pulse from a neighbouring timer |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| osc_clk_i | input | 1 | Independent oscillator clock |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register address: 0 mode, 1 wrap flag |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for `bus_addr_i` |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect at the edge that samples it, so a raw-clock or timer-pulse advance shows one edge later. A divided advance shows exactly 12 or 4 edges after the select-changing write. A pin edge needs two synchronizer flops plus the edge detector, so it reaches the count three edges after the transition. The oscillator path is checked a few clocks after each burst, once the synchronizer has settled. The bench drives inputs and samples outputs on falling edges. It counts rising edges from each write and checks the count delta, the flag and the request at exactly those points: one edge before a divided advance is due and on the edge it is due.

// File: rtl/cnt_tbsel_pkg.sv
package cnt_tbsel_pkg;

    typedef enum logic [2:0] {
        TB_DIV12 = 3'b000,
        TB_DIV4  = 3'b001,
        TB_T0    = 3'b010,
        TB_PIN   = 3'b011,
        TB_SYS   = 3'b100,
        TB_OSC   = 3'b101,
        TB_RSV6  = 3'b110,
        TB_RSV7  = 3'b111
    } tb_sel_e;

    typedef struct packed {
        logic    idle_hold;
        tb_sel_e sel;
        logic    irq_en;
    } mode_t;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;

endpackage

// File: rtl/cnt_tbsel_prescale.sv
module cnt_tbsel_prescale #(
    parameter int DIV = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr_i) begin
            pre_d.phase = '0;
        end else if (run_i) begin
            pre_d.phase = (pre_q.phase == LAST) ? '0 : pre_q.phase + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assign tick_o = run_i && (pre_q.phase == LAST);

endmodule

// File: rtl/cnt_tbsel_sync.sv
module cnt_tbsel_sync #(
    parameter int STAGES = 2,
    parameter logic INIT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  settled;

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = {sy_q.chain[STAGES-2:0], async_i};
        sy_d.prev  = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '{chain: {STAGES{INIT}}, prev: INIT};
        else         sy_q <= sy_d;
    end

    assign settled = sy_q.chain[STAGES-1];
    assign rise_o  = settled && !sy_q.prev;
    assign fall_o  = !settled && sy_q.prev;

endmodule

// File: rtl/cnt_tbsel_oscdiv.sv
module cnt_tbsel_oscdiv #(
    parameter int LOG2_DIV = 3
) (
    input  logic osc_clk_i,
    input  logic rst_ni,
    output logic half_o
);
    typedef struct packed {
        logic [LOG2_DIV-1:0] cnt;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d     = dv_q;
        dv_d.cnt = dv_q.cnt + LOG2_DIV'(1);
    end

    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) dv_q <= '0;
        else         dv_q <= dv_d;
    end

    assign half_o = dv_q.cnt[LOG2_DIV-1];

endmodule

// File: rtl/cnt_tbsel_top.sv
module cnt_tbsel_top
    import cnt_tbsel_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int SLOW_DIV     = 12,
    parameter int FAST_DIV     = 4,
    parameter int OSC_LOG2_DIV = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             idle_i,
    input  logic             t0_ovf_i,
    input  logic             ext_cnt_i,
    input  logic             osc_clk_i,
    input  logic             bus_we_i,
    input  logic             bus_addr_i,
    input  logic [7:0]       bus_wdata_i,
    output logic [7:0]       bus_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);
    localparam int NUM_PRE = 2;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
        mode_t            mode;
    } st_t;

    st_t   st_d, st_q;
    mode_t mode_q;

    logic  run;
    logic  mode_wr, flag_wr, sel_chg;
    logic  tick;
    logic  [NUM_PRE-1:0] pre_tick;
    logic  pin_fall, pin_rise_unused;
    logic  osc_half, osc_rise, osc_fall_unused;
    logic  unused_wbits;

    assign unused_wbits = ^bus_wdata_i[6:4];

    assign run     = !(st_q.mode.idle_hold && idle_i);
    assign mode_wr = bus_we_i && (bus_addr_i == ADDR_MODE);
    assign flag_wr = bus_we_i && (bus_addr_i == ADDR_FLAG);
    assign sel_chg = mode_wr && (bus_wdata_i[3:1] != st_q.mode.sel);

    // Fixed prescalers of the system clock; both restart on a select change.
    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        localparam int THIS_DIV = (g == 0) ? SLOW_DIV : FAST_DIV;
        cnt_tbsel_prescale #(.DIV(THIS_DIV)) u_pre (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (sel_chg),
            .run_i  (run),
            .tick_o (pre_tick[g])
        );
    end

    // External pin: synchronize, then detect high-to-low.
    cnt_tbsel_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_cnt_i),
        .rise_o  (pin_rise_unused),
        .fall_o  (pin_fall)
    );

    // Oscillator divided in its own domain, its top bit brought across.
    cnt_tbsel_oscdiv #(.LOG2_DIV(OSC_LOG2_DIV)) u_osc_div (
        .osc_clk_i (osc_clk_i),
        .rst_ni    (rst_ni),
        .half_o    (osc_half)
    );

    cnt_tbsel_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_osc_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (osc_half),
        .rise_o  (osc_rise),
        .fall_o  (osc_fall_unused)
    );

    always_comb begin
        case (st_q.mode.sel)
            TB_DIV12: tick = pre_tick[0];
            TB_DIV4:  tick = pre_tick[1];
            TB_T0:    tick = t0_ovf_i;
            TB_PIN:   tick = pin_fall;
            TB_SYS:   tick = 1'b1;
            TB_OSC:   tick = osc_rise;
            default:  tick = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (run && tick) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
        if (mode_wr) begin
            st_d.mode.idle_hold = bus_wdata_i[7];
            st_d.mode.sel       = tb_sel_e'(bus_wdata_i[3:1]);
            st_d.mode.irq_en    = bus_wdata_i[0];
        end
        if (flag_wr && !bus_wdata_i[0]) begin
            st_d.flag = 1'b0;
        end
        if (run && tick && (st_q.count == CNT_TOP)) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        if (bus_addr_i == ADDR_MODE) begin
            bus_rdata_o = {st_q.mode.idle_hold, 3'b000, st_q.mode.sel, st_q.mode.irq_en};
        end else begin
            bus_rdata_o = {7'b0000000, st_q.flag};
        end
    end

    assign mode_q  = st_q.mode;
    assign count_o = st_q.count;
    assign ovf_o   = st_q.flag;
    assign irq_o   = st_q.flag && st_q.mode.irq_en;

endmodule

// File: rtl/cnt_tbsel_chk.sv
module cnt_tbsel_chk
    import cnt_tbsel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             idle_i,
    input mode_t            mode_q,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             irq_o
);
    // R9: reserved selects never advance
    p_reserved_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q.sel[2:1] == 2'b11) |=> $stable(count_o));

    // R10: idle freeze holds the count
    p_idle_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q.idle_hold && idle_i) |=> $stable(count_o));

    // R6: raw clock timebase steps every edge when running
    p_sys_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_q.sel == TB_SYS) && !(mode_q.idle_hold && idle_i))
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R11: a wrap leaves the flag set
    p_wrap_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((count_o == '0) && ($past(count_o) == {CNT_W{1'b1}})) |-> ovf_o);

    // R12: request only with flag and enable
    p_irq_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ovf_o && mode_q.irq_en));

    // R13: at most one step per clock
    p_single_step_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

bind cnt_tbsel_top cnt_tbsel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (idle_i),
    .mode_q  (mode_q),
    .count_o (count_o),
    .ovf_o   (ovf_o),
    .irq_o   (irq_o)
);

// File: tb/tb_cnt_tbsel_top.sv
module tb_cnt_tbsel_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        idle_i = 1'b0;
    logic        t0_ovf_i = 1'b0;
    logic        ext_cnt_i = 1'b1;
    logic        osc_clk_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic        bus_addr_i = 1'b0;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [7:0]  bus_rdata_o;
    logic [15:0] count_o;
    logic        ovf_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [15:0] base;

    cnt_tbsel_top dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .idle_i      (idle_i),
        .t0_ovf_i    (t0_ovf_i),
        .ext_cnt_i   (ext_cnt_i),
        .osc_clk_i   (osc_clk_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .count_o     (count_o),
        .ovf_o       (ovf_o),
        .irq_o       (irq_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] data);
        @(negedge clk_i);
        bus_we_i    = 1'b1;
        bus_addr_i  = addr;
        bus_wdata_i = data;
        @(negedge clk_i);
        bus_we_i    = 1'b0;
    endtask

    task automatic freeze();
        bus_write(1'b0, 8'h0C);
        @(negedge clk_i);
        base = count_o;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic osc_burst(input int n);
        repeat (n) begin
            #7 osc_clk_i = 1'b1;
            #7 osc_clk_i = 1'b0;
        end
    endtask

    task automatic pin_pulse(input int low_clks, input int high_clks);
        @(negedge clk_i);
        ext_cnt_i = 1'b0;
        wait_edges(low_clks);
        ext_cnt_i = 1'b1;
        wait_edges(high_clks - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] m;
        wait_edges(3);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state (counter already running at divide-by-12: first step due at edge 12)
        bus_addr_i = 1'b0;
        #1 check("R1 mode", bus_rdata_o, 8'h00);
        check("R1 count", count_o, 16'h0000);
        check("R1 flag", ovf_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);

        // R2 readback sweep over every byte
        for (int v = 0; v < 256; v++) begin
            bus_write(1'b0, 8'(v));
            bus_addr_i = 1'b0;
            #1 check("R2 readback", bus_rdata_o, 8'(v) & 8'h8F);
        end

        // R9 both reserved selects hold
        for (int s = 6; s < 8; s++) begin
            bus_write(1'b0, 8'(s << 1));
            @(negedge clk_i);
            base = count_o;
            t0_ovf_i = 1'b1;
            wait_edges(30);
            t0_ovf_i = 1'b0;
            check("R9 reserved hold", count_o, base);
        end

        // R3 divide by 12 with restart
        freeze();
        bus_write(1'b0, 8'h00);
        wait_edges(11);
        check("R3 before first", count_o, base);
        @(negedge clk_i);
        check("R3 first", count_o, base + 16'd1);
        wait_edges(12 * 4 - 1);
        check("R3 before fifth", count_o, base + 16'd4);
        @(negedge clk_i);
        check("R3 fifth", count_o, base + 16'd5);

        // R4 divide by 4 with restart
        freeze();
        bus_write(1'b0, 8'h02);
        wait_edges(3);
        check("R4 before first", count_o, base);
        @(negedge clk_i);
        check("R4 first", count_o, base + 16'd1);
        wait_edges(4 * 9);
        check("R4 tenth", count_o, base + 16'd10);

        // R5 timer pulse
        freeze();
        bus_write(1'b0, 8'h04);
        wait_edges(5);
        check("R5 no pulse", count_o, base);
        t0_ovf_i = 1'b1;
        @(negedge clk_i);
        t0_ovf_i = 1'b0;
        check("R5 single", count_o, base + 16'd1);
        wait_edges(2);
        t0_ovf_i = 1'b1;
        wait_edges(3);
        t0_ovf_i = 1'b0;
        check("R5 back to back", count_o, base + 16'd4);

        // R6 raw clock
        freeze();
        bus_write(1'b0, 8'h08);
        wait_edges(1);
        check("R6 one edge", count_o, base + 16'd1);
        wait_edges(99);
        check("R6 hundred", count_o, base + 16'd100);

        // R7 pin falling edges, fastest and slower patterns
        freeze();
        bus_write(1'b0, 8'h06);
        for (int p = 0; p < 6; p++) pin_pulse(2, 2);
        wait_edges(4);
        check("R7 fast pulses", count_o, base + 16'd6);
        @(negedge clk_i);
        ext_cnt_i = 1'b0;
        wait_edges(2);
        check("R7 not yet", count_o, base + 16'd6);
        @(negedge clk_i);
        check("R7 latency", count_o, base + 16'd7);
        wait_edges(2);
        ext_cnt_i = 1'b1;
        for (int p = 0; p < 3; p++) pin_pulse(5, 3);
        wait_edges(4);
        check("R7 slow pulses", count_o, base + 16'd10);

        // R8 oscillator over 8
        freeze();
        bus_write(1'b0, 8'h0A);
        osc_burst(40);
        wait_edges(6);
        check("R8 forty osc", count_o, base + 16'd5);
        osc_burst(24);
        wait_edges(6);
        check("R8 twenty-four osc", count_o, base + 16'd8);

        // R10 idle freeze
        freeze();
        idle_i = 1'b1;
        bus_write(1'b0, 8'h88);
        wait_edges(20);
        check("R10 frozen", count_o, base);
        idle_i = 1'b0;
        wait_edges(10);
        check("R10 resumed", count_o, base + 16'd10);
        freeze();
        idle_i = 1'b1;
        bus_write(1'b0, 8'h08);
        wait_edges(10);
        idle_i = 1'b0;
        check("R10 hold bit clear", count_o, base + 16'd10);

        // R11 and R12 wrap, flag, request
        freeze();
        m = 16'hFFFF - base;
        bus_write(1'b0, 8'h09);
        wait_edges(int'(m));
        check("R11 at top", count_o, 16'hFFFF);
        check("R11 flag before wrap", ovf_o, 1'b0);
        check("R12 irq before wrap", irq_o, 1'b0);
        @(negedge clk_i);
        check("R11 wrapped", count_o, 16'h0000);
        check("R11 flag set", ovf_o, 1'b1);
        check("R12 irq set", irq_o, 1'b1);
        bus_write(1'b0, 8'h0C);
        check("R12 irq masked", irq_o, 1'b0);
        check("R11 flag sticky", ovf_o, 1'b1);
        bus_write(1'b1, 8'h01);
        bus_addr_i = 1'b1;
        #1 check("R11 write one keeps", bus_rdata_o, 8'h01);
        bus_write(1'b0, 8'h0D);
        check("R12 irq re-enabled", irq_o, 1'b1);
        bus_write(1'b1, 8'h00);
        bus_addr_i = 1'b1;
        #1 check("R11 cleared", bus_rdata_o, 8'h00);
        check("R12 irq after clear", irq_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule